// File: doc/BRIEF.md
# Panel Command Bus Engine

This block drives the eight-bit-style parallel command bus of a smart LCD panel controller, where the bus is widened to a parameterised data width of 16 bits by default. The panel has two chip selects, one for a main panel and one for a sub panel, plus write, read and register-select strobes. Software controls the block through a small register port. It places a 32-bit command word in a staging register, and flag bits in the upper byte mark that word as an index (command) write or a data write. Writing a go register then launches one bus transfer.

A panel read works in a similar way. Software first arms a read request by writing a flag into the read-data register, then writes a separate read-go register. At the end of the active strobe phase the engine samples the panel bus, and the sampled 16-bit value comes back through the low half of the read-data register.

Every transfer passes through a setup phase, an active phase and a hold phase. The length of each phase is a parameter. A status register shows a busy flag while a transfer is in progress, and software polls that flag before it issues the next go.

Top module: `pcb_engine`

## Requirements
- R1: After reset, both chip selects, the write strobe and the read strobe are high, the data driver is off, and reads of STATUS (0x04) and READ-DATA (0x0C) return 0.
- R2: A write of 1 in bit 0 to WR_GO (0x08) starts a write cycle, but only when the word in CMD (0x00) has bit 28 set. Bit 24 of that word sets register-select: 0 gives an index cycle (rs low) and 1 gives a data cycle (rs high). The bus carries CMD[15:0] with the driver enabled for the whole transfer.
- R3: Bit 1 of the go write selects the target. A value of 0 drives chip select 0 (main) low and a value of 1 drives chip select 1 (sub) low. At most one chip select is ever low.
- R4: Phase timing (defaults of 2/2/2). Busy is set in the cycle after the go write. The active strobe stays high for SETUP_CYC cycles, then goes low for ACTIVE_CYC cycles, then stays high for HOLD_CYC cycles. After that, busy and the chip select are released. A transfer is therefore busy for exactly SETUP_CYC+ACTIVE_CYC+HOLD_CYC cycles.
- R5: A go write that arrives while busy is set has no effect. It neither lengthens the transfer nor changes its target.
- R6: A WR_GO write is ignored if CMD bit 28 is clear or if the go value has bit 0 clear.
- R7: Writing READ-DATA (0x0C) with bit 24 set arms a read, and a following RD_GO (0x10) bit-0 write launches it. The launched read drives rs high with the driver off and the read strobe low in the active phase. The bus is sampled in the last active cycle. A later read of READ-DATA returns the sample in bits 15:0 and zero in bits 31:16.
- R8: RD_GO is ignored unless a read is armed. Each launched read consumes the armed request. Writing READ-DATA with bit 24 clear disarms it.
- R9: STATUS reads bit 1 as busy and all other bits as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, decoded combinationally from reg_addr_i |
| panel_cs_no | output | 2 | Chip selects, active low (bit 0 main, bit 1 sub) |
| panel_wr_no | output | 1 | Write strobe, active low |
| panel_rd_no | output | 1 | Read strobe, active low |
| panel_rs_o | output | 1 | Register select (0 index, 1 data) |
| panel_d_o | output | PANEL_W | Bus data out |
| panel_d_oe_o | output | 1 | Bus driver enable |
| panel_d_i | input | PANEL_W | Bus data in |

## Verification
The hardest situation to reach from the ports is a second go write that lands in the middle of a running transfer, aimed at the other panel. To hit it, the bench issues that second go write one cycle after a launch. It then follows the chip selects, the strobes and the busy bit cycle by cycle to the end of the transfer, which shows that neither the length nor the target changed. Stale read launches are a second hard case. The bench reaches them by issuing RD_GO again after a completed read and after a disarming write, and it confirms that the captured value stays unchanged.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned REG_W = 32;

  // word index of each register (byte address >> 2)
  localparam logic [2:0] IDX_CMD    = 3'd0;
  localparam logic [2:0] IDX_STATUS = 3'd1;
  localparam logic [2:0] IDX_WR_GO  = 3'd2;
  localparam logic [2:0] IDX_RDATA  = 3'd3;
  localparam logic [2:0] IDX_RD_GO  = 3'd4;

  localparam int unsigned BIT_CMD_VALID = 28;
  localparam int unsigned BIT_CMD_DATA  = 24;
  localparam int unsigned BIT_RD_ARM    = 24;
  localparam int unsigned BIT_GO        = 0;
  localparam int unsigned BIT_GO_SUB    = 1;
  localparam int unsigned BIT_BUSY      = 1;

  localparam int unsigned NUM_PANEL = 2;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  typedef struct packed {
    logic is_read;
    logic rs;
    logic sub;
  } xfer_ctl_t;
endpackage

// File: rtl/pcb_regs.sv
module pcb_regs
  import pcb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned PANEL_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               busy_i,
  input  logic               cap_en_i,
  input  logic [PANEL_W-1:0] cap_data_i,
  output logic               launch_o,
  output xfer_ctl_t          launch_ctl_o,
  output logic [PANEL_W-1:0] launch_data_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [REG_W-1:0]   cmd_q;
  logic               arm_q;
  logic [PANEL_W-1:0] cap_q;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             hit_cmd, hit_wgo, hit_rdata, hit_rgo, hit_status;
  logic             wr_ok, rd_ok;

  assign idx     = reg_addr_i[ADDR_W-1:2];
  assign aligned = (reg_addr_i[1:0] == 2'b00);

  assign hit_cmd    = aligned && (idx == IDX_W'(IDX_CMD));
  assign hit_status = aligned && (idx == IDX_W'(IDX_STATUS));
  assign hit_wgo    = aligned && (idx == IDX_W'(IDX_WR_GO));
  assign hit_rdata  = aligned && (idx == IDX_W'(IDX_RDATA));
  assign hit_rgo    = aligned && (idx == IDX_W'(IDX_RD_GO));

  assign wr_ok = reg_we_i && hit_wgo && reg_wdata_i[BIT_GO] && cmd_q[BIT_CMD_VALID];
  assign rd_ok = reg_we_i && hit_rgo && reg_wdata_i[BIT_GO] && arm_q;

  assign launch_o              = (wr_ok || rd_ok) && !busy_i;
  assign launch_ctl_o.is_read  = rd_ok;
  assign launch_ctl_o.rs       = rd_ok ? 1'b1 : cmd_q[BIT_CMD_DATA];
  assign launch_ctl_o.sub      = reg_wdata_i[BIT_GO_SUB];
  assign launch_data_o         = cmd_q[PANEL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      arm_q <= 1'b0;
      cap_q <= '0;
    end else begin
      if (reg_we_i && hit_cmd) cmd_q <= reg_wdata_i;
      if (reg_we_i && hit_rdata) arm_q <= reg_wdata_i[BIT_RD_ARM];
      else if (rd_ok && !busy_i) arm_q <= 1'b0;
      if (cap_en_i) cap_q <= cap_data_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (hit_cmd)    reg_rdata_o = cmd_q;
    if (hit_status) reg_rdata_o[BIT_BUSY] = busy_i;
    if (hit_rdata)  reg_rdata_o[PANEL_W-1:0] = cap_q;
  end
endmodule

// File: rtl/pcb_seq.sv
module pcb_seq
  import pcb_pkg::*;
#(
  parameter int unsigned PANEL_W    = 16,
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned ACTIVE_CYC = 2,
  parameter int unsigned HOLD_CYC   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  xfer_ctl_t          launch_ctl_i,
  input  logic [PANEL_W-1:0] launch_data_i,
  output phase_e             phase_o,
  output xfer_ctl_t          ctl_o,
  output logic [PANEL_W-1:0] data_o,
  output logic               busy_o,
  output logic               cap_en_o
);
  localparam int unsigned MAX_A = (SETUP_CYC > ACTIVE_CYC) ? SETUP_CYC : ACTIVE_CYC;
  localparam int unsigned MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int unsigned CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(ACTIVE_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_H = CNT_W'(HOLD_CYC - 1);

  phase_e             ph_q;
  logic [CNT_W-1:0]   cnt_q;
  xfer_ctl_t          ctl_q;
  logic [PANEL_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      ctl_q  <= '0;
      data_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (launch_i) begin
            ph_q   <= PH_SETUP;
            cnt_q  <= '0;
            ctl_q  <= launch_ctl_i;
            data_q <= launch_data_i;
          end
        end
        PH_SETUP: begin
          if (cnt_q == LAST_S) begin
            ph_q  <= PH_ACT;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_ACT: begin
          if (cnt_q == LAST_A) begin
            ph_q  <= PH_HOLD;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_HOLD: begin
          if (cnt_q == LAST_H) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = ph_q;
  assign ctl_o    = ctl_q;
  assign data_o   = data_q;
  assign busy_o   = (ph_q != PH_IDLE);
  assign cap_en_o = (ph_q == PH_ACT) && (cnt_q == LAST_A) && ctl_q.is_read;
endmodule

// File: rtl/pcb_pins.sv
module pcb_pins
  import pcb_pkg::*;
#(
  parameter int unsigned PANEL_W = 16
) (
  input  phase_e             phase_i,
  input  xfer_ctl_t          ctl_i,
  input  logic [PANEL_W-1:0] data_i,
  output logic [NUM_PANEL-1:0] cs_no,
  output logic               wr_no,
  output logic               rd_no,
  output logic               rs_o,
  output logic [PANEL_W-1:0] d_o,
  output logic               d_oe_o
);
  logic active, busy;

  assign busy   = (phase_i != PH_IDLE);
  assign active = (phase_i == PH_ACT);

  for (genvar p = 0; p < NUM_PANEL; p++) begin : g_cs
    assign cs_no[p] = !(busy && (ctl_i.sub == p[0]));
  end

  assign wr_no  = !(active && !ctl_i.is_read);
  assign rd_no  = !(active && ctl_i.is_read);
  assign rs_o   = busy ? ctl_i.rs : 1'b0;
  assign d_oe_o = busy && !ctl_i.is_read;
  assign d_o    = d_oe_o ? data_i : '0;
endmodule

// File: rtl/pcb_engine.sv
module pcb_engine
  import pcb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned PANEL_W    = 16,
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned ACTIVE_CYC = 2,
  parameter int unsigned HOLD_CYC   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic [1:0]         panel_cs_no,
  output logic               panel_wr_no,
  output logic               panel_rd_no,
  output logic               panel_rs_o,
  output logic [PANEL_W-1:0] panel_d_o,
  output logic               panel_d_oe_o,
  input  logic [PANEL_W-1:0] panel_d_i
);
  logic               busy;
  logic               cap_en;
  logic               launch;
  xfer_ctl_t          launch_ctl;
  logic [PANEL_W-1:0] launch_data;
  phase_e             phase;
  xfer_ctl_t          ctl;
  logic [PANEL_W-1:0] data;

  pcb_regs #(.ADDR_W(ADDR_W), .PANEL_W(PANEL_W)) regs_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .busy_i        (busy),
    .cap_en_i      (cap_en),
    .cap_data_i    (panel_d_i),
    .launch_o      (launch),
    .launch_ctl_o  (launch_ctl),
    .launch_data_o (launch_data)
  );

  pcb_seq #(
    .PANEL_W(PANEL_W), .SETUP_CYC(SETUP_CYC),
    .ACTIVE_CYC(ACTIVE_CYC), .HOLD_CYC(HOLD_CYC)
  ) seq_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_i      (launch),
    .launch_ctl_i  (launch_ctl),
    .launch_data_i (launch_data),
    .phase_o       (phase),
    .ctl_o         (ctl),
    .data_o        (data),
    .busy_o        (busy),
    .cap_en_o      (cap_en)
  );

  pcb_pins #(.PANEL_W(PANEL_W)) pins_i (
    .phase_i (phase),
    .ctl_i   (ctl),
    .data_i  (data),
    .cs_no   (panel_cs_no),
    .wr_no   (panel_wr_no),
    .rd_no   (panel_rd_no),
    .rs_o    (panel_rs_o),
    .d_o     (panel_d_o),
    .d_oe_o  (panel_d_oe_o)
  );
endmodule

// File: rtl/pcb_engine_chk.sv
module pcb_engine_chk #(
  parameter int unsigned PANEL_W   = 16,
  parameter int unsigned TOTAL_CYC = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_i,
  input logic [1:0]         cs_n_i,
  input logic               wr_n_i,
  input logic               rd_n_i,
  input logic               rs_i,
  input logic [PANEL_W-1:0] d_i,
  input logic               oe_i
);
  logic [31:0] busy_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run_q <= '0;
    else if (busy_i) busy_run_q <= busy_run_q + 1;
    else busy_run_q <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i == 2'b11) |-> (wr_n_i && rd_n_i && !oe_i)); // R1
  AST_WRITE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_i |-> oe_i); // R2
  AST_WRITE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(rs_i) && $stable(d_i))); // R2
  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_i) <= 1); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!wr_n_i && !rd_n_i)); // R4
  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_i || !rd_n_i) |-> (cs_n_i != 2'b11)); // R4
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run_q <= TOTAL_CYC); // R4
  AST_TARGET_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(cs_n_i)); // R5
  AST_READ_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_i |-> (!oe_i && rs_i)); // R7
endmodule

bind pcb_engine pcb_engine_chk #(
  .PANEL_W(PANEL_W), .TOTAL_CYC(SETUP_CYC + ACTIVE_CYC + HOLD_CYC)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy),
  .cs_n_i (panel_cs_no),
  .wr_n_i (panel_wr_no),
  .rd_n_i (panel_rd_no),
  .rs_i   (panel_rs_o),
  .d_i    (panel_d_o),
  .oe_i   (panel_d_oe_o)
);

// File: tb/pcb_engine_tb_top.sv
module pcb_engine_tb_top;
  localparam logic [4:0] A_CMD = 5'h00, A_STAT = 5'h04, A_WGO = 5'h08,
                         A_RDAT = 5'h0C, A_RGO = 5'h10;
  localparam int N_VEC = 4;
  // {cmd word, go value, rs, cs_n, bus data}
  localparam logic [52:0] VEC [N_VEC] = '{
    {32'h1000_00A5, 2'b01, 1'b0, 2'b10, 16'h00A5},
    {32'h1100_1234, 2'b01, 1'b1, 2'b10, 16'h1234},
    {32'h1000_0036, 2'b11, 1'b0, 2'b01, 16'h0036},
    {32'h1100_BEEF, 2'b11, 1'b1, 2'b01, 16'hBEEF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [4:0] addr = A_STAT;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0] cs_n;
  logic wr_n, rd_n, rs, oe;
  logic [15:0] d_o;
  logic [15:0] d_in = '0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcb_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .panel_cs_no(cs_n),
    .panel_wr_no(wr_n), .panel_rd_no(rd_n), .panel_rs_o(rs),
    .panel_d_o(d_o), .panel_d_oe_o(oe), .panel_d_i(d_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; addr = A_STAT;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = A_STAT;
    #1;
  endtask

  // walk a transfer from cycle k0 (0 = first busy cycle) to idle
  task automatic follow(input int k0, input logic is_rd, input logic [1:0] cs_e,
                        input logic rs_e, input logic [15:0] d_e, input string req);
    logic [31:0] st;
    for (int k = k0; k <= 6; k++) begin
      automatic logic act = (k == 2 || k == 3);
      automatic logic bsy = (k < 6);
      reg_rd(A_STAT, st);
      chk({req, " R9 busy"}, st, bsy ? 32'h2 : 32'h0);
      chk({req, " R3 cs"}, {30'b0, cs_n}, {30'b0, bsy ? cs_e : 2'b11});
      chk({req, " R4 wr"}, {31'b0, wr_n}, {31'b0, !(act && !is_rd)});
      chk({req, " R4 rd"}, {31'b0, rd_n}, {31'b0, !(act && is_rd)});
      chk({req, " R2 oe"}, {31'b0, oe}, {31'b0, bsy && !is_rd});
      if (bsy) chk({req, " R2 rs"}, {31'b0, rs}, {31'b0, rs_e});
      if (bsy && !is_rd) chk({req, " R2 data"}, {16'b0, d_o}, {16'b0, d_e});
      if (k < 6) @(negedge clk);
    end
  endtask

  task automatic idle_for(input int n, input string req);
    logic [31:0] st;
    for (int i = 0; i < n; i++) begin
      reg_rd(A_STAT, st);
      chk({req, " busy"}, st, 32'h0);
      chk({req, " cs"}, {30'b0, cs_n}, 32'h3);
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs", {30'b0, cs_n}, 32'h3);
    chk("R1 wr/rd", {30'b0, wr_n, rd_n}, 32'h3);
    chk("R1 oe", {31'b0, oe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_rd(A_STAT, v); chk("R1 status", v, 32'h0);
    reg_rd(A_RDAT, v); chk("R1 rdata", v, 32'h0);

    // table of write transfers: R2 R3 R4
    for (int i = 0; i < N_VEC; i++) begin
      reg_wr(A_CMD, VEC[i][52:21]);
      reg_rd(A_CMD, v); chk("R2 cmd readback", v, VEC[i][52:21]);
      reg_wr(A_WGO, {30'b0, VEC[i][20:19]});
      follow(0, 1'b0, VEC[i][17:16], VEC[i][18], VEC[i][15:0], "R2 vec");
    end

    // R5 go during busy, aimed at the other panel
    reg_wr(A_CMD, 32'h1100_0F0F);
    reg_wr(A_WGO, 32'h1);
    reg_wr(A_WGO, 32'h3);
    follow(1, 1'b0, 2'b10, 1'b1, 16'h0F0F, "R5 ignore");
    idle_for(2, "R5 no relaunch");

    // R6 invalid word or missing go bit
    reg_wr(A_CMD, 32'h0100_0011);
    reg_wr(A_WGO, 32'h1);
    idle_for(7, "R6 bit28 clear");
    reg_wr(A_CMD, 32'h1000_0011);
    reg_wr(A_WGO, 32'h2);
    idle_for(7, "R6 bit0 clear");

    // R7 reads on both panels
    d_in = 16'hC3A5;
    reg_wr(A_RDAT, 32'h0100_0000);
    reg_wr(A_RGO, 32'h1);
    follow(0, 1'b1, 2'b10, 1'b1, 16'h0, "R7 main read");
    reg_rd(A_RDAT, v); chk("R7 main value", v, 32'h0000_C3A5);
    d_in = 16'h5A5A;
    reg_wr(A_RDAT, 32'h0100_0000);
    reg_wr(A_RGO, 32'h3);
    follow(0, 1'b1, 2'b01, 1'b1, 16'h0, "R7 sub read");
    reg_rd(A_RDAT, v); chk("R7 sub value", v, 32'h0000_5A5A);

    // R8 stale or disarmed read launch
    d_in = 16'h1111;
    reg_wr(A_RGO, 32'h1);
    idle_for(7, "R8 consumed");
    reg_rd(A_RDAT, v); chk("R8 value kept", v, 32'h0000_5A5A);
    reg_wr(A_RDAT, 32'h0100_0000);
    reg_wr(A_RDAT, 32'h0000_0000);
    reg_wr(A_RGO, 32'h1);
    idle_for(7, "R8 disarmed");
    reg_rd(A_RDAT, v); chk("R8 value kept 2", v, 32'h0000_5A5A);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule